// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers eight level-sensitive PCI interrupt lines (PIRQ A through H) and one system control interrupt (SCI) onto two sets of interrupt controller inputs at the same time. The first set is 16 legacy PIC inputs. The second set is 24 APIC global system interrupt (GSI) lines.

For the PIC side, each PIRQ has a route byte. The route byte names a target PIC input, or it blocks the PIRQ from the PIC entirely. Several PIRQs may share one PIC input; that input is then the OR of their levels. On the APIC side each PIRQ owns a fixed pin that no other PIRQ shares. A separate SCI control byte picks one of five destinations for the SCI, or no destination at all.

A combinational route query reports, for each PIRQ, where an interrupt controller can expect to see it. Firmware and the interrupt-routing logic upstream use this result to learn the effective mapping. Configuration arrives over a simple synchronous byte write port. The SCI input is registered once inside the block; every other output is a combinational function of the stored configuration and the input levels.

Top module: `pirq_irq_router`

## Requirements
- R1: After a synchronous active-low reset, all eight route bytes hold 0x80, which means PIC routing is blocked. The SCI control byte holds 0x00, which steers the SCI to interrupt 9. The registered SCI level is 0.
- R2: A write with `wr_en` high stores `wr_data` at the rising clock edge. Addresses 0 to 3 hold the route bytes of PIRQ A to D, addresses 4 to 7 hold those of E to H, and address 8 holds the SCI control byte. Writes to addresses 9 to 15 change nothing.
- R3: In a route byte, bit 7 set blocks PIC routing and bits 4:0 give the target interrupt number. Bits 6:5 have no effect.
- R4: PIC input k is the OR of the levels of every PIRQ whose route byte has bit 7 clear and target equal to k. It is also ORed with the registered SCI level when the SCI is steered to k.
- R5: A PIRQ whose route is unblocked but whose target is 16 or more drives no PIC input.
- R6: GSI 16+n equals the level of PIRQ n, ORed with the SCI level when the SCI is steered to 16+n.
- R7: The SCI control byte bits 2:0 select the SCI destination: code 0 gives 9, 1 gives 10, 2 gives 11, 4 gives 20 and 5 gives 21. Codes 3, 6 and 7 route the SCI nowhere. Bits 7:3 have no effect.
- R8: `sci_in` is registered. A change on it reaches the PIC and GSI outputs one clock edge later, not in the same cycle. The GSI at the selected destination is always driven, and the PIC input is driven too when the destination is below 16.
- R9: The route query for PIRQ n depends on its route byte. If bit 7 is set, it returns enabled with number 16+n. If bit 7 is clear and the target is below 16, it returns enabled with the target. If bit 7 is clear and the target is 16 or more, it returns disabled with number 0xFF (meaning -1). Query n sits at `qry_irq[8n+7:8n]`.
- R10: GSIs 0 to 15 carry nothing but the SCI, so at most one of them is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 4 | Register address of the write |
| wr_data | input | 8 | Byte to store |
| pirq_lvl | input | 8 | Levels of PIRQ A (bit 0) to H (bit 7) |
| sci_in | input | 1 | System control interrupt level |
| pic_o | output | 16 | Legacy PIC inputs, bit k is interrupt k |
| gsi_o | output | 24 | APIC GSI lines, bit g is GSI g |
| qry_en | output | 8 | Route query enabled flag per PIRQ |
| qry_irq | output | 64 | Route query number per PIRQ, 8 bits each |

## Verification
The hardest situation to reach from the ports is one where several PIRQs and the SCI all land on the same PIC input, and one of them is then removed. That removal can happen in three ways: the line drops, its route byte is blocked, or its target moves to 16 or more. The OR must then still hold exactly as long as one contributor remains. The stimulus reaches this in three parts. It sweeps each PIRQ over all 32 target values in both blocked and unblocked form, under single-line, all-lines and idle level patterns. It writes pseudo-random route bytes to all eight PIRQs so that targets collide. It steps the SCI through every select code, including the codes that collide with PIRQ-owned GSIs 20 and 21, and samples both before and after the register edge.

// File: rtl/irt_pkg.sv
// Shared types and helpers for the PIRQ interrupt router.
// Assumes a route byte with a blocking flag in bit 7 and a 5-bit target.
package irt_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned TGT_W    = 5;
    localparam int unsigned SEL_W    = 3;
    localparam logic [7:0]  ROUTE_RST = 8'h80;
    localparam logic [7:0]  SCI_RST   = 8'h00;
    localparam logic [7:0]  IRQ_NONE  = 8'hFF;

    // Stored form of one route byte (bits 6:5 are not kept)
    typedef struct packed {
        logic             blocked;
        logic [TGT_W-1:0] tgt;
    } route_t;

    // Decoded SCI destination
    typedef struct packed {
        logic             hit;
        logic [TGT_W-1:0] dest;
    } sci_dest_t;

    // Translate the SCI select code into a destination interrupt number
    function automatic sci_dest_t sci_decode(input logic [SEL_W-1:0] code);
        sci_dest_t d;
        d.hit  = 1'b1;
        d.dest = '0;
        case (code)
            3'd0:    d.dest = TGT_W'(9);
            3'd1:    d.dest = TGT_W'(10);
            3'd2:    d.dest = TGT_W'(11);
            3'd4:    d.dest = TGT_W'(20);
            3'd5:    d.dest = TGT_W'(21);
            default: d.hit  = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/irt_cfg_regs.sv
// Configuration register file: one route byte per PIRQ plus the SCI select.
// Assumes route bytes at addresses 0..NUM_PIRQ-1 and SCI select right after.
module irt_cfg_regs
    import irt_pkg::*;
#(
    parameter int unsigned NUM_PIRQ = 8,
    parameter int unsigned ADDR_W   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [BYTE_W-1:0]           wr_data,
    output route_t [NUM_PIRQ-1:0]       routes_o,
    output logic [SEL_W-1:0]            sci_sel_o
);

    localparam logic [ADDR_W-1:0] SCI_ADDR = ADDR_W'(NUM_PIRQ);

    // Bits of the byte that no register keeps
    logic [1:0] unused_wr_bits;
    assign unused_wr_bits = wr_data[6:5];

    for (genvar i = 0; i < NUM_PIRQ; i++) begin : g_route
        // Hold route byte i; load the reset default or a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                routes_o[i] <= route_t'({ROUTE_RST[7], ROUTE_RST[TGT_W-1:0]});
            end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                routes_o[i] <= route_t'({wr_data[7], wr_data[TGT_W-1:0]});
            end
        end
    end

    // Hold the SCI select field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sci_sel_o <= SCI_RST[SEL_W-1:0];
        end else if (wr_en && wr_addr == SCI_ADDR) begin
            sci_sel_o <= wr_data[SEL_W-1:0];
        end
    end

    // R2: writes above the SCI address leave every register untouched
    a_r2_stray_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > SCI_ADDR) |=> ($stable(routes_o) && $stable(sci_sel_o)));

endmodule

// File: rtl/irt_pic_merge.sv
// Builds each legacy PIC input as the OR of all PIRQs and the SCI aimed at it.
// Assumes targets of NUM_PIC or more simply match no line.
module irt_pic_merge
    import irt_pkg::*;
#(
    parameter int unsigned NUM_PIRQ = 8,
    parameter int unsigned NUM_PIC  = 16
) (
    input  route_t [NUM_PIRQ-1:0] routes_i,
    input  logic [NUM_PIRQ-1:0]   pirq_lvl_i,
    input  logic                  sci_lvl_i,
    input  sci_dest_t             sci_dest_i,
    output logic [NUM_PIC-1:0]    pic_o
);

    for (genvar k = 0; k < NUM_PIC; k++) begin : g_line
        logic [NUM_PIRQ-1:0] pick;

        // Select the PIRQs that are unblocked and aimed at line k
        always_comb begin
            for (int n = 0; n < NUM_PIRQ; n++) begin
                pick[n] = !routes_i[n].blocked && (routes_i[n].tgt == TGT_W'(k));
            end
        end

        // OR the picked levels with the SCI when it is steered here
        always_comb begin
            pic_o[k] = |(pick & pirq_lvl_i)
                     | (sci_lvl_i && sci_dest_i.hit && sci_dest_i.dest == TGT_W'(k));
        end
    end

endmodule

// File: rtl/irt_gsi_map.sv
// Drives the APIC lines: PIRQ n owns GSI NUM_PIC+n, the SCI joins its destination.
// Assumes NUM_GSI covers NUM_PIC+NUM_PIRQ lines.
module irt_gsi_map
    import irt_pkg::*;
#(
    parameter int unsigned NUM_PIRQ = 8,
    parameter int unsigned NUM_PIC  = 16,
    parameter int unsigned NUM_GSI  = 24
) (
    input  logic [NUM_PIRQ-1:0] pirq_lvl_i,
    input  logic                sci_lvl_i,
    input  sci_dest_t           sci_dest_i,
    output logic [NUM_GSI-1:0]  gsi_o
);

    localparam int unsigned SPARE_GSI = NUM_GSI - NUM_PIC - NUM_PIRQ;

    // Place the PIRQ levels on their own pins and add the SCI
    always_comb begin
        gsi_o = '0;
        gsi_o[NUM_PIC +: NUM_PIRQ] = pirq_lvl_i;
        if (sci_dest_i.hit && int'(sci_dest_i.dest) < NUM_GSI) begin
            gsi_o[int'(sci_dest_i.dest)] = gsi_o[int'(sci_dest_i.dest)] | sci_lvl_i;
        end
    end

    if (NUM_GSI < NUM_PIC + NUM_PIRQ) begin : g_bad_size
        initial $error("irt_gsi_map: NUM_GSI too small, spare %0d", SPARE_GSI);
    end

endmodule

// File: rtl/irt_route_query.sv
// Answers, per PIRQ, whether it reaches a controller and at which number.
// Assumes a blocked PIC route means the PIRQ is seen on its own GSI.
module irt_route_query
    import irt_pkg::*;
#(
    parameter int unsigned NUM_PIRQ = 8,
    parameter int unsigned NUM_PIC  = 16
) (
    input  route_t [NUM_PIRQ-1:0]         routes_i,
    output logic [NUM_PIRQ-1:0]           qry_en_o,
    output logic [NUM_PIRQ*BYTE_W-1:0]    qry_irq_o
);

    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_query
        // Resolve the three routing cases for PIRQ n
        always_comb begin
            if (routes_i[n].blocked) begin
                qry_en_o[n]                 = 1'b1;
                qry_irq_o[n*BYTE_W +: BYTE_W] = BYTE_W'(NUM_PIC + n);
            end else if (int'(routes_i[n].tgt) < NUM_PIC) begin
                qry_en_o[n]                 = 1'b1;
                qry_irq_o[n*BYTE_W +: BYTE_W] = BYTE_W'(routes_i[n].tgt);
            end else begin
                qry_en_o[n]                 = 1'b0;
                qry_irq_o[n*BYTE_W +: BYTE_W] = IRQ_NONE;
            end
        end
    end

endmodule

// File: rtl/pirq_irq_router.sv
// Top of the PIRQ router: register file, SCI level register, PIC merge,
// GSI map and route query. Assumes synchronous active-low reset.
module pirq_irq_router
    import irt_pkg::*;
#(
    parameter int unsigned NUM_PIRQ = 8,
    parameter int unsigned NUM_PIC  = 16,
    parameter int unsigned NUM_GSI  = 24,
    parameter int unsigned ADDR_W   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [7:0]                    wr_data,
    input  logic [NUM_PIRQ-1:0]           pirq_lvl,
    input  logic                          sci_in,
    output logic [NUM_PIC-1:0]            pic_o,
    output logic [NUM_GSI-1:0]            gsi_o,
    output logic [NUM_PIRQ-1:0]           qry_en,
    output logic [NUM_PIRQ*8-1:0]         qry_irq
);

    route_t [NUM_PIRQ-1:0] routes;
    logic [SEL_W-1:0]      sci_sel;
    sci_dest_t             sci_dest;
    logic                  sci_q;

    irt_cfg_regs #(.NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .routes_o  (routes),
        .sci_sel_o (sci_sel)
    );

    // Decode the SCI select code into a destination
    always_comb sci_dest = sci_decode(sci_sel);

    // Register the SCI level so only real changes propagate
    always_ff @(posedge clk) begin
        if (!rst_n) sci_q <= 1'b0;
        else        sci_q <= sci_in;
    end

    irt_pic_merge #(.NUM_PIRQ(NUM_PIRQ), .NUM_PIC(NUM_PIC)) pic_i (
        .routes_i   (routes),
        .pirq_lvl_i (pirq_lvl),
        .sci_lvl_i  (sci_q),
        .sci_dest_i (sci_dest),
        .pic_o      (pic_o)
    );

    irt_gsi_map #(.NUM_PIRQ(NUM_PIRQ), .NUM_PIC(NUM_PIC), .NUM_GSI(NUM_GSI)) gsi_i (
        .pirq_lvl_i (pirq_lvl),
        .sci_lvl_i  (sci_q),
        .sci_dest_i (sci_dest),
        .gsi_o      (gsi_o)
    );

    irt_route_query #(.NUM_PIRQ(NUM_PIRQ), .NUM_PIC(NUM_PIC)) qry_i (
        .routes_i  (routes),
        .qry_en_o  (qry_en),
        .qry_irq_o (qry_irq)
    );

    // R8: the registered SCI follows its input exactly one edge later
    a_r8_sci_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (sci_in != sci_q) |=> (sci_q == $past(sci_in)));

    // R6: a raised PIRQ is always visible on its own GSI
    a_r6_gsi_owns_pirq: assert property (@(posedge clk) disable iff (!rst_n)
        ((pirq_lvl & ~gsi_o[NUM_PIC +: NUM_PIRQ]) == '0));

    // R10: the low GSIs carry only the SCI, so never more than one is high
    a_r10_low_gsi_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gsi_o[NUM_PIC-1:0]));

    // R4: with no PIRQ and no SCI active every PIC input is low
    a_r4_pic_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((pirq_lvl == '0) && !sci_q) |-> (pic_o == '0));

    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_qchk
        // R9: a disabled query always reports the no-interrupt number
        a_r9_disabled_none: assert property (@(posedge clk) disable iff (!rst_n)
            !qry_en[n] |-> (qry_irq[n*8 +: 8] == IRQ_NONE));
    end

endmodule

// File: tb/pirq_irq_router_tb_top.sv
`timescale 1ns/1ps
module pirq_irq_router_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [7:0]  pirq_lvl;
    logic        sci_in;
    logic [15:0] pic_o;
    logic [23:0] gsi_o;
    logic [7:0]  qry_en;
    logic [63:0] qry_irq;

    always #2 clk = ~clk;

    pirq_irq_router dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pirq_lvl(pirq_lvl), .sci_in(sci_in),
        .pic_o(pic_o), .gsi_o(gsi_o), .qry_en(qry_en), .qry_irq(qry_irq)
    );

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    logic [7:0] m_route [8];
    logic [7:0] m_sci_ctl;
    logic       m_sci_q;
    logic [31:0] lfsr = 32'h1D2C3B4A;

    function automatic int sci_dest(input logic [7:0] ctl);
        case (ctl[2:0])
            3'd0: return 9;
            3'd1: return 10;
            3'd2: return 11;
            3'd4: return 20;
            3'd5: return 21;
            default: return -1;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output with values computed from the model state
    task automatic check_all(input string tag);
        logic [15:0] e_pic;
        logic [23:0] e_gsi;
        logic [7:0]  e_en;
        logic [63:0] e_irq;
        int d;
        e_pic = '0; e_gsi = '0; e_en = '0; e_irq = '0;
        for (int n = 0; n < 8; n++) begin
            e_gsi[16+n] = pirq_lvl[n];
            if (m_route[n][7]) begin
                e_en[n] = 1'b1; e_irq[n*8 +: 8] = 8'(16 + n);
            end else if (m_route[n][4:0] < 5'd16) begin
                e_en[n] = 1'b1; e_irq[n*8 +: 8] = {3'b0, m_route[n][4:0]};
                e_pic[m_route[n][3:0]] = e_pic[m_route[n][3:0]] | pirq_lvl[n];
            end else begin
                e_en[n] = 1'b0; e_irq[n*8 +: 8] = 8'hFF;
            end
        end
        d = sci_dest(m_sci_ctl);
        if (d >= 0) begin
            e_gsi[d] = e_gsi[d] | m_sci_q;
            if (d < 16) e_pic[d] = e_pic[d] | m_sci_q;
        end
        chk({tag, " pic"}, 64'(pic_o), 64'(e_pic));
        chk({tag, " gsi"}, 64'(gsi_o), 64'(e_gsi));
        chk({tag, " qry_en"}, 64'(qry_en), 64'(e_en));
        chk({tag, " qry_irq"}, qry_irq, e_irq);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 4'd8)       m_route[a[2:0]] = d;
        else if (a == 4'd8) m_sci_ctl = d;
    endtask

    task automatic set_pirq(input logic [7:0] p);
        pirq_lvl = p;
        #1;
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        pirq_lvl = 8'h00; sci_in = 1'b1;
        for (int n = 0; n < 8; n++) m_route[n] = 8'h80;
        m_sci_ctl = 8'h00; m_sci_q = 1'b0;
        repeat (3) @(negedge clk);
        sci_in = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset defaults, every PIRQ blocked from the PIC
        set_pirq(8'hA5);
        check_all("R1 reset");

        // R3 R4 R5 R9: sweep each PIRQ over every target, blocked and not
        for (int n = 0; n < 8; n++) begin
            for (int t = 0; t < 32; t++) begin
                for (int b = 0; b < 2; b++) begin
                    wr(4'(n), {b[0], 2'b00, 5'(t)});
                    set_pirq(8'(1 << n));
                    check_all(t >= 16 ? "R5 single" : "R4 single");
                    set_pirq(8'hFF);
                    check_all("R9 all");
                    set_pirq(8'h00);
                    check_all("R3 idle");
                end
            end
            wr(4'(n), 8'h80);
        end

        // R3: bits 6:5 carry no meaning
        wr(4'd2, 8'h67);
        set_pirq(8'h04);
        check_all("R3 spare bits");
        wr(4'd2, 8'h80);

        // R2 R4 R6: random route bytes so targets collide
        for (int i = 0; i < 300; i++) begin
            step_lfsr();
            wr(4'(lfsr[2:0]), lfsr[15:8] & 8'h8F);
            step_lfsr();
            set_pirq(lfsr[7:0]);
            check_all("R4 shared");
            step_lfsr();
            if (lfsr[3:0] == 4'd0) begin
                set_pirq(8'h00);
                check_all("R6 drop");
            end
        end

        // R2: stray addresses change nothing
        set_pirq(8'hC3);
        for (int a = 9; a < 16; a++) begin
            wr(4'(a), 8'h05);
            check_all("R2 stray");
        end

        // R7 R8 R10: every SCI select code, edge lag checked
        for (int c = 0; c < 8; c++) begin
            wr(4'd8, 8'(c) | 8'hF8 & 8'h00 | (c[0] ? 8'h50 : 8'h00));
            for (int p = 0; p < 2; p++) begin
                set_pirq(p == 0 ? 8'h00 : 8'h30);
                @(negedge clk);
                sci_in = 1'b1; #1;
                check_all("R8 before edge");
                @(negedge clk);
                m_sci_q = 1'b1; #1;
                check_all("R7 sci high");
                chk("R10 low gsi", 64'($countones(gsi_o[15:0]) <= 1), 64'd1);
                sci_in = 1'b0; #1;
                check_all("R8 hold");
                @(negedge clk);
                m_sci_q = 1'b0; #1;
                check_all("R7 sci low");
            end
        end

        // R4: SCI and PIRQ share one PIC line, one leaves
        wr(4'd8, 8'h01);
        wr(4'd3, 8'h0A);
        set_pirq(8'h08);
        @(negedge clk); sci_in = 1'b1;
        @(negedge clk); m_sci_q = 1'b1; #1;
        check_all("R4 sci+pirq");
        set_pirq(8'h00);
        check_all("R4 sci only");
        wr(4'd3, 8'h8A);
        set_pirq(8'h08);
        check_all("R4 pirq blocked");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

endmodule